// File: doc/BRIEF.md
# Three-Area Paged Address Translator

This block widens a 16-bit logical CPU address into a 20-bit physical address. The logical space is split into up to three areas. A low area is always mapped to physical zero. A middle "bank" area and a top "high" area are each relocated by an 8-bit page base of their own. Pages are 4 KB. The upper logical nibble is the logical page number, and the lower twelve bits are the offset inside the page.

The CPU programs the mapping through three 8-bit I/O registers. The limits register holds the start pages of the high area and the bank area. The other two registers are the bank page base and the high page base. The register port has an address, write data, a write strobe and a read strobe. A write is captured on the rising clock edge. Translation is purely combinational from the logical address and the current register contents. A register write therefore applies to the access that follows the write cycle. The block adds the selected page base to the logical page number, keeps the low eight bits of the sum as physical bits [19:12], and passes the offset through unchanged.

Top module: `seg_xlat`

## Requirements
- R1: Synchronous active-high reset sets the high page base (I/O 0x38) to 0x00, the bank page base (I/O 0x39) to 0x00 and the limits register (I/O 0x3A) to 0xF0, so after reset every logical address maps to the same physical address.
- R2: Registers sit at I/O 0x38 (high base), 0x39 (bank base) and 0x3A (limits). All 8 bits of each register can be written and read back. A write to any other I/O address changes no register. Reading an unmapped address returns 0x00.
- R3: When the logical page (bits [15:12]) is below the bank start page (limits bits [3:0]) and below the high start page (limits bits [7:4]), the access is in the low area and the physical address is the logical address zero-extended to 20 bits.
- R4: Physical bits [11:0] always equal logical bits [11:0].
- R5: When the logical page is at or above the high start page (limits bits [7:4]), physical bits [19:12] equal the high page base plus the logical page.
- R6: When the logical page is at or above the bank start page but below the high start page, physical bits [19:12] equal the bank page base plus the logical page. When the high start page is at or below the bank start page, the high area takes precedence and no bank area exists.
- R7: The page-base sum is taken modulo 256 pages, so any carry out of physical bit 19 is dropped.
- R8: Translation follows the logical address within the same cycle. During the cycle in which a base or limits write is presented, the old mapping still applies. From the clock edge that captures the write onward, the new mapping applies.
- R9: `io_rdata` is 0x00 whenever `io_rd` is low. Reads never change any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O register address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | Write strobe, captured at the rising edge |
| io_rd | input | 1 | Read strobe, gates combinational read data |
| io_rdata | output | 8 | Read data from the addressed register, or zero |
| log_addr | input | 16 | Logical address of the current access |
| phys_addr | output | 20 | Translated physical address |

## Verification
The translation is swept over all sixteen logical pages under several register settings:
- The reset identity map.
- A layout with distinct low, bank and high areas and different bases, which shows which base each area uses and where each boundary falls.
- An inverted layout with the high start page below the bank start page, which shows that the high area takes precedence.
- A high base that overflows, which shows that the page carry is dropped.

Register access is tested with complementary bit patterns and with writes to neighbouring unmapped addresses. The update timing is checked by observing the physical address inside the write cycle and again after the capturing edge.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int LOG_W    = 16;
    localparam int PAGE_W   = 4;
    localparam int OFS_W    = LOG_W - PAGE_W;
    localparam int BASE_W   = 8;
    localparam int PHYS_W   = BASE_W + OFS_W;
    localparam int IO_AW    = 8;
    localparam int IO_DW    = 8;
    localparam int NUM_REGS = 3;

    // register slot order relative to the I/O base address
    localparam int SLOT_HIGH_BASE = 0;
    localparam int SLOT_BANK_BASE = 1;
    localparam int SLOT_LIMITS    = 2;

    typedef enum logic [1:0] {
        AREA_LOW  = 2'd0,
        AREA_BANK = 2'd1,
        AREA_HIGH = 2'd2
    } area_e;

    typedef struct packed {
        logic [PAGE_W-1:0] high_start;
        logic [PAGE_W-1:0] bank_start;
    } limits_t;

    typedef struct packed {
        limits_t           limits;
        logic [BASE_W-1:0] bank_base;
        logic [BASE_W-1:0] high_base;
    } map_cfg_t;

    function automatic logic [BASE_W-1:0] page_sum(input logic [BASE_W-1:0] base,
                                                   input logic [PAGE_W-1:0] page);
        return base + BASE_W'(page);
    endfunction

endpackage

// File: rtl/seg_xlat_regs.sv
module seg_xlat_regs
    import seg_xlat_pkg::*;
#(
    parameter logic [IO_AW-1:0] IO_BASE    = 8'h38,
    parameter logic [IO_DW-1:0] LIMITS_RST = 8'hF0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [IO_DW-1:0] io_wdata,
    input  logic             io_wr,
    input  logic             io_rd,
    output logic [IO_DW-1:0] io_rdata,
    output map_cfg_t         cfg_o
);

    logic [IO_DW-1:0] regs_q [NUM_REGS];
    logic [NUM_REGS-1:0] sel;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [IO_AW-1:0] MY_ADDR = IO_AW'(int'(IO_BASE) + i);
        localparam logic [IO_DW-1:0] MY_RST  = (i == SLOT_LIMITS) ? LIMITS_RST : '0;

        assign sel[i] = (io_addr == MY_ADDR);

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= MY_RST;
            end else if (io_wr && sel[i]) begin
                regs_q[i] <= io_wdata;
            end
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (sel[i]) io_rdata = regs_q[i];
            end
        end
    end

    assign cfg_o.high_base = regs_q[SLOT_HIGH_BASE];
    assign cfg_o.bank_base = regs_q[SLOT_BANK_BASE];
    assign cfg_o.limits    = limits_t'(regs_q[SLOT_LIMITS]);

    AST_RESET_MAP: assert property (@(posedge clk)
        rst |=> (cfg_o == {LIMITS_RST, {BASE_W{1'b0}}, {BASE_W{1'b0}}})); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !io_wr |=> $stable(cfg_o)); // R2

endmodule

// File: rtl/seg_xlat_classify.sv
module seg_xlat_classify
    import seg_xlat_pkg::*;
(
    input  limits_t           limits,
    input  logic [PAGE_W-1:0] page,
    output area_e             area
);

    logic in_high;
    logic in_bank;

    // the high area is tested first and wins any overlap
    assign in_high = (page >= limits.high_start);
    assign in_bank = (page >= limits.bank_start);

    always_comb begin
        if (in_high)      area = AREA_HIGH;
        else if (in_bank) area = AREA_BANK;
        else              area = AREA_LOW;
    end

endmodule

// File: rtl/seg_xlat_adder.sv
module seg_xlat_adder
    import seg_xlat_pkg::*;
(
    input  area_e             area,
    input  map_cfg_t          cfg,
    input  logic [LOG_W-1:0]  log_addr,
    output logic [PHYS_W-1:0] phys_addr
);

    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  offset;
    logic [BASE_W-1:0] base;
    logic [BASE_W-1:0] phys_page;

    assign page   = log_addr[LOG_W-1:OFS_W];
    assign offset = log_addr[OFS_W-1:0];

    always_comb begin
        unique case (area)
            AREA_HIGH: base = cfg.high_base;
            AREA_BANK: base = cfg.bank_base;
            default:   base = '0;
        endcase
    end

    assign phys_page = page_sum(base, page);
    assign phys_addr = {phys_page, offset};

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter logic [IO_AW-1:0] IO_BASE    = 8'h38,
    parameter logic [IO_DW-1:0] LIMITS_RST = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [IO_DW-1:0]  io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [IO_DW-1:0]  io_rdata,
    input  logic [LOG_W-1:0]  log_addr,
    output logic [PHYS_W-1:0] phys_addr
);

    map_cfg_t          cfg;
    area_e             area;
    logic [PAGE_W-1:0] page;

    assign page = log_addr[LOG_W-1:OFS_W];

    seg_xlat_regs #(
        .IO_BASE    (IO_BASE),
        .LIMITS_RST (LIMITS_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_rdata (io_rdata),
        .cfg_o    (cfg)
    );

    seg_xlat_classify u_classify (
        .limits (cfg.limits),
        .page   (page),
        .area   (area)
    );

    seg_xlat_adder u_adder (
        .area      (area),
        .cfg       (cfg),
        .log_addr  (log_addr),
        .phys_addr (phys_addr)
    );

    AST_LOW_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (area == AREA_LOW) |-> (phys_addr == PHYS_W'(log_addr))); // R3

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFS_W-1:0] == log_addr[OFS_W-1:0]); // R4

    AST_HIGH_BASE: assert property (@(posedge clk) disable iff (rst)
        (page >= cfg.limits.high_start) |->
        (phys_addr[PHYS_W-1:OFS_W] == BASE_W'(cfg.high_base + BASE_W'(page)))); // R5

    AST_BANK_BELOW_HIGH: assert property (@(posedge clk) disable iff (rst)
        (area == AREA_BANK) |-> (page < cfg.limits.high_start)); // R6

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == '0)); // R9

endmodule

// File: tb/seg_xlat_bench.sv
module seg_xlat_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [15:0] log_addr = '0;
    logic [19:0] phys_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // bench-side copy of the programmed registers
    logic [7:0] sh_hb  = 8'h00;
    logic [7:0] sh_bb  = 8'h00;
    logic [7:0] sh_lim = 8'hF0;

    always #2.5 clk = ~clk;

    seg_xlat u_seg_xlat (
        .clk       (clk),
        .rst       (rst),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_rdata  (io_rdata),
        .log_addr  (log_addr),
        .phys_addr (phys_addr)
    );

    function automatic logic [19:0] model(input logic [15:0] a, input logic [7:0] lim,
                                          input logic [7:0] bb, input logic [7:0] hb);
        logic [3:0] p;
        logic [7:0] b;
        logic [7:0] s;
        p = a[15:12];
        if (p >= lim[7:4])      b = hb;
        else if (p >= lim[3:0]) b = bb;
        else                    return {4'h0, a};
        s = b + {4'h0, p};
        return {s, a[11:0]};
    endfunction

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == 8'h38) sh_hb = d;
        if (a == 8'h39) sh_bb = d;
        if (a == 8'h3A) sh_lim = d;
    endtask

    task automatic io_read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        check(req, {12'h0, io_rdata}, {12'h0, exp});
        io_rd = 1'b0;
    endtask

    task automatic sweep(input string req);
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            log_addr = {p[3:0], 12'hA5C ^ 12'(p * 37)};
            #1;
            check(req, phys_addr, model(log_addr, sh_lim, sh_bb, sh_hb));
        end
    endtask

    task automatic t_reset;
        io_read_check("R1 high base reset", 8'h38, 8'h00);
        io_read_check("R1 bank base reset", 8'h39, 8'h00);
        io_read_check("R1 limits reset", 8'h3A, 8'hF0);
        @(negedge clk); log_addr = 16'h0000; #1;
        check("R1 identity low end", phys_addr, 20'h00000);
        @(negedge clk); log_addr = 16'hFFFF; #1;
        check("R1 identity high end", phys_addr, 20'h0FFFF);
        @(negedge clk); log_addr = 16'h7123; #1;
        check("R1 identity mid", phys_addr, 20'h07123);
    endtask

    task automatic t_regs;
        io_write(8'h38, 8'hA5); io_write(8'h39, 8'h5A); io_write(8'h3A, 8'h3C);
        io_read_check("R2 high base rw", 8'h38, 8'hA5);
        io_read_check("R2 bank base rw", 8'h39, 8'h5A);
        io_read_check("R2 limits rw", 8'h3A, 8'h3C);
        io_write(8'h38, 8'h5A); io_write(8'h39, 8'hA5); io_write(8'h3A, 8'hC3);
        io_read_check("R2 high base rw inv", 8'h38, 8'h5A);
        io_read_check("R2 bank base rw inv", 8'h39, 8'hA5);
        io_read_check("R2 limits rw inv", 8'h3A, 8'hC3);
        @(negedge clk);
        io_addr = 8'h37; io_wdata = 8'hFF; io_wr = 1'b1;
        @(negedge clk);
        io_addr = 8'h3B;
        @(negedge clk);
        io_addr = 8'hB9;
        @(negedge clk);
        io_wr = 1'b0;
        io_read_check("R2 unmapped write high base", 8'h38, 8'h5A);
        io_read_check("R2 unmapped write bank base", 8'h39, 8'hA5);
        io_read_check("R2 unmapped write limits", 8'h3A, 8'hC3);
        io_read_check("R2 unmapped read", 8'h3B, 8'h00);
    endtask

    task automatic t_areas;
        io_write(8'h3A, 8'hC4); io_write(8'h39, 8'h20); io_write(8'h38, 8'h30);
        sweep("R3 R4 R5 R6 three areas");
        @(negedge clk); log_addr = 16'h3FFF; #1;
        check("R3 last low page", phys_addr, 20'h03FFF);
        @(negedge clk); log_addr = 16'h4000; #1;
        check("R6 first bank page", phys_addr, 20'h24000);
        @(negedge clk); log_addr = 16'hBFFF; #1;
        check("R6 last bank page", phys_addr, 20'h2BFFF);
        @(negedge clk); log_addr = 16'hC001; #1;
        check("R5 first high page", phys_addr, 20'h3C001);
    endtask

    task automatic t_overlap;
        io_write(8'h3A, 8'h48); io_write(8'h39, 8'h70); io_write(8'h38, 8'h10);
        sweep("R6 high precedence");
        @(negedge clk); log_addr = 16'h9ABC; #1;
        check("R6 overlap uses high base", phys_addr, 20'h19ABC);
        @(negedge clk); log_addr = 16'h3ABC; #1;
        check("R3 below both starts", phys_addr, 20'h03ABC);
    endtask

    task automatic t_carry;
        io_write(8'h3A, 8'hE2); io_write(8'h38, 8'hFF); io_write(8'h39, 8'hFE);
        @(negedge clk); log_addr = 16'hF123; #1;
        check("R7 high carry dropped", phys_addr, 20'h0E123);
        @(negedge clk); log_addr = 16'hD456; #1;
        check("R7 bank carry dropped", phys_addr, 20'h0B456);
        sweep("R7 wrap sweep");
    endtask

    task automatic t_timing;
        io_write(8'h3A, 8'hF1); io_write(8'h39, 8'h40);
        @(negedge clk);
        log_addr = 16'h5678;
        io_addr = 8'h39; io_wdata = 8'h80; io_wr = 1'b1;
        #1;
        check("R8 old map in write cycle", phys_addr, 20'h45678);
        @(posedge clk); #1;
        check("R8 new map after edge", phys_addr, 20'h85678);
        @(negedge clk);
        io_wr = 1'b0; sh_bb = 8'h80;
        log_addr = 16'h2001; #1;
        check("R8 combinational follow", phys_addr, 20'h82001);
    endtask

    task automatic t_read_quiet;
        @(negedge clk);
        io_addr = 8'h39; io_rd = 1'b0; #1;
        check("R9 rdata zero without strobe", {12'h0, io_rdata}, 20'h0);
        io_read_check("R9 read once", 8'h39, 8'h80);
        io_read_check("R9 read twice unchanged", 8'h39, 8'h80);
        @(negedge clk); log_addr = 16'h1000; #1;
        check("R9 map unchanged by reads", phys_addr, model(16'h1000, sh_lim, sh_bb, sh_hb));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_areas();
        t_overlap();
        t_carry();
        t_timing();
        t_read_quiet();
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule